// File: doc/BRIEF.md
# Fixed-Priority Nested Interrupt Controller

This block gathers fourteen interrupt sources and offers one at a time to a processor core. Seven sources are external pins: a power-monitor input and six general request pins. Seven are internal one-cycle pulses from peripherals: three serial-channel completions and four timer ticks. Each pin passes through a two-flop synchronizer and an edge detector. A detected edge or pulse latches a pending flag when that source is enabled. A fixed priority chain picks the most urgent pending flag.

The core sees a request line and a vector. It takes the offer with an acknowledge pulse, which clears that flag and pushes the level onto an in-service stack. A return strobe pops the stack. A pending source is offered only when it outranks the level on top of the stack, so a more urgent event can preempt a running handler while a less urgent one waits. The stack has a bounded depth. A preemption that would exceed it is held back and flagged as overflow.

The control port is a write-only register port with three addresses:
- Address 0 holds the per-source enables.
- Address 1 holds the edge polarity of the six general pins.
- Address 2 is a write-one-to-clear strobe for the pending flags and for the power-fail status bit.

A state machine summarises the arbitration. `ST_IDLE` means the stack is empty and nothing is offered. `ST_OFFER` means a request is presented. `ST_BUSY` means a handler runs and nothing pending outranks it. `ST_FULL` means a preempting request is blocked because the stack is full. The state is recomputed every cycle from the updated flags and stack, so any state can move to any other:
- ST_IDLE→ST_OFFER: a flag latches.
- ST_OFFER→ST_BUSY: an acknowledge leaves nothing more urgent.
- ST_BUSY→ST_OFFER: preemption.
- ST_BUSY→ST_IDLE: the last return.
- ST_BUSY→ST_FULL: a preempting request arrives at the depth limit.
- ST_FULL→ST_OFFER: a return frees a slot.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `irq_req` and `nest_ovf` are 0, `nest_depth` is 0, all `pend_flags` are 0, `hold_on` is 0, and all enables and polarities are 0.
- R2: Source numbers, and the vector values presented, run from most to least urgent:
  - 0: power monitor
  - 1 to 6: general pins 0 to 5
  - 7 to 9: serial channels 0 to 2, carried on `per_pulse[0..2]`
  - 10 to 13: timers 0 to 3, carried on `per_pulse[3..6]`
  
  When a request is offered, `irq_vec` is the lowest-numbered pending source.
- R3: Bit i of the polarity register (address 1) chooses rising (1) or falling (0) edges for general pin i. An edge of the other direction sets no flag.
- R4: The power-monitor pin reacts only to falling edges. A falling edge sets `hold_on` whatever the enable, and sets flag 0 only if source 0 is enabled. Writing address 2 with bit 14 set clears `hold_on`.
- R5: Bit s of the enable register (address 0) gates source s. An edge or pulse on a disabled source leaves its flag at 0.
- R6: A flag stays set until it is acknowledged or cleared. Further edges or pulses while it is set are absorbed, so one acknowledge consumes them all.
- R7: An `irq_ack` in a cycle with `irq_req` high clears the flag of `irq_vec` and increments `nest_depth`. An `irq_ack` while `irq_req` is low changes nothing.
- R8: A pending source is offered only if `nest_depth` is 0 or its number is strictly lower than the level on top of the stack. Otherwise it stays pending with `irq_req` low.
- R9: `irq_ret` decrements `nest_depth` and exposes the previous level. At depth 0 it is ignored.
- R10: When a preempting request exists and `nest_depth` equals `NEST_MAX`, `nest_ovf` is 1 and `irq_req` is 0. After a return, the request is offered and `nest_ovf` falls.
- R11: A pin level change first sampled at clock edge k sets its flag at edge k+2. An internal pulse sampled at edge k sets its flag at edge k. `irq_req` follows the flag in the same cycle.
- R12: Writing address 2 clears every pending flag whose bit is 1 in bits 13:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_hold | input | 1 | Raw power-monitor pin |
| pin_int | input | 6 | Raw general request pins 0 to 5 |
| per_pulse | input | 7 | Internal peripheral pulses: serial 0 to 2, then timers 0 to 3 |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_addr | input | 2 | Control register address |
| ctrl_wdata | input | 15 | Control register write data |
| irq_ack | input | 1 | Core accepts the offered vector |
| irq_ret | input | 1 | Core returns from the current handler |
| irq_req | output | 1 | A request is offered |
| irq_vec | output | 4 | Number of the offered source |
| nest_ovf | output | 1 | Preemption blocked by a full stack |
| nest_depth | output | $clog2(NEST_MAX+1) | Number of handlers in service |
| pend_flags | output | 14 | Latched pending flags |
| hold_on | output | 1 | Power-fail status |

## Verification
Simultaneous internal pulses on three sources, and a pin edge racing a pulse, show whether the priority chain picks the right winner and whether the pin path carries its extra synchronizer latency. Repeated pulses on an in-service source, followed by a pulse from a more urgent source, separate the equal-level wait from true preemption and show that absorbed edges yield a single request. Pin toggles in both directions under each polarity setting, with sources enabled and disabled, show whether only the selected edges of enabled sources latch. A second instance with a shallow stack is nested to its limit, so the overflow block and its release on return can be observed.

// File: rtl/irqn_pkg.sv
package irqn_pkg;
    localparam int NSRC  = 14;               // total request sources
    localparam int NGEN  = 6;                // general request pins
    localparam int NPIN  = NGEN + 1;         // plus the power-monitor pin
    localparam int NPER  = NSRC - NPIN;      // internal peripheral pulses
    localparam int VW    = $clog2(NSRC);     // vector width
    localparam int CW    = NSRC + 1;         // control data width
    localparam int HOLD_CLR_BIT = NSRC;      // bit clearing the power-fail status

    localparam logic [1:0] REG_ENA = 2'd0;
    localparam logic [1:0] REG_POL = 2'd1;
    localparam logic [1:0] REG_CLR = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_BUSY  = 2'd2,
        ST_FULL  = 2'd3
    } nest_st_e;
endpackage

// File: rtl/irqn_pin_front.sv
module irqn_pin_front #(
    parameter int NP = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] pin_raw,
    input  logic [NP-2:0] pol_rise,
    output logic [NP-1:0] edge_det
);
    logic [NP-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= pin_raw;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    for (genvar i = 0; i < NP; i++) begin : g_pin
        if (i == 0) begin : g_fall_only
            // power monitor: falling edge only
            assign edge_det[i] = s3_q[i] & ~s2_q[i];
        end else begin : g_sel
            assign edge_det[i] = pol_rise[i-1] ? (s2_q[i] & ~s3_q[i])
                                               : (s3_q[i] & ~s2_q[i]);
        end
    end
endmodule

// File: rtl/irqn_pend.sv
module irqn_pend #(
    parameter int N = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_req,
    input  logic [N-1:0] clr_req,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] flags_q,
    output logic [N-1:0] flags_d
);
    // a set in the same cycle as a clear wins
    always_comb flags_d = (flags_q & ~clr_req & ~ack_clr) | set_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/irqn_prio.sv
module irqn_prio #(
    parameter int N = 14,
    parameter int W = 4
) (
    input  logic [N-1:0] req,
    output logic         valid,
    output logic [W-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/irqn_stack.sv
module irqn_stack #(
    parameter int DEPTH = 16,
    parameter int LW    = 4,
    parameter int DW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [LW-1:0] push_lvl,
    output logic [DW-1:0] depth_q,
    output logic [DW-1:0] depth_d,
    output logic [LW-1:0] top_d
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LW-1:0] mem [DEPTH];
    logic          pop_eff, push_eff;
    logic [DW-1:0] wr_pos, rd_pos;

    always_comb begin
        pop_eff  = pop && (depth_q != '0);
        wr_pos   = depth_q - DW'(pop_eff);
        push_eff = push && (wr_pos < DW'(DEPTH));
        depth_d  = wr_pos + DW'(push_eff);
        rd_pos   = depth_d - DW'(1);
        if (push_eff)             top_d = push_lvl;
        else if (depth_d == '0)   top_d = '0;
        else                      top_d = mem[IW'(rd_pos)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) depth_q <= '0;
        else        depth_q <= depth_d;
    end

    always_ff @(posedge clk) begin
        if (push_eff) mem[IW'(wr_pos)] <= push_lvl;
    end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irqn_pkg::*;
#(
    parameter  int NEST_MAX = 16,
    localparam int DW       = $clog2(NEST_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_hold,
    input  logic [NGEN-1:0] pin_int,
    input  logic [NPER-1:0] per_pulse,
    input  logic            ctrl_we,
    input  logic [1:0]      ctrl_addr,
    input  logic [CW-1:0]   ctrl_wdata,
    input  logic            irq_ack,
    input  logic            irq_ret,
    output logic            irq_req,
    output logic [VW-1:0]   irq_vec,
    output logic            nest_ovf,
    output logic [DW-1:0]   nest_depth,
    output logic [NSRC-1:0] pend_flags,
    output logic            hold_on
);
    logic [NSRC-1:0] ena_q;
    logic [NGEN-1:0] pol_q;
    logic            hold_on_q;
    logic [NPIN-1:0] pin_edge;
    logic [NSRC-1:0] set_req, clr_req, ack_clr, flags_q, flags_d;
    logic            wr_ena, wr_pol, wr_clr, ack_take;
    logic            cand_v, preempt;
    logic [VW-1:0]   cand_i, vec_q, top_d;
    logic [DW-1:0]   depth_q, depth_d;
    nest_st_e        state_q, state_d;

    // control register writes
    always_comb begin
        wr_ena  = ctrl_we && (ctrl_addr == REG_ENA);
        wr_pol  = ctrl_we && (ctrl_addr == REG_POL);
        wr_clr  = ctrl_we && (ctrl_addr == REG_CLR);
        clr_req = wr_clr ? ctrl_wdata[NSRC-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q     <= '0;
            pol_q     <= '0;
            hold_on_q <= 1'b0;
        end else begin
            if (wr_ena) ena_q <= ctrl_wdata[NSRC-1:0];
            if (wr_pol) pol_q <= ctrl_wdata[NGEN-1:0];
            if (pin_edge[0])                              hold_on_q <= 1'b1;
            else if (wr_clr && ctrl_wdata[HOLD_CLR_BIT])  hold_on_q <= 1'b0;
        end
    end

    irqn_pin_front #(.NP(NPIN)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  ({pin_int, pin_hold}),
        .pol_rise (pol_q),
        .edge_det (pin_edge)
    );

    always_comb begin
        set_req  = {per_pulse, pin_edge} & ena_q;
        ack_take = irq_ack && (state_q == ST_OFFER);
        ack_clr  = ack_take ? (NSRC'(1) << vec_q) : '0;
    end

    irqn_pend #(.N(NSRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr_req (clr_req),
        .ack_clr (ack_clr),
        .flags_q (flags_q),
        .flags_d (flags_d)
    );

    irqn_stack #(.DEPTH(NEST_MAX), .LW(VW), .DW(DW)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ack_take),
        .pop      (irq_ret),
        .push_lvl (vec_q),
        .depth_q  (depth_q),
        .depth_d  (depth_d),
        .top_d    (top_d)
    );

    irqn_prio #(.N(NSRC), .W(VW)) u_prio (
        .req   (flags_d),
        .valid (cand_v),
        .idx   (cand_i)
    );

    // next-state decision from the post-update flags and stack
    always_comb begin
        preempt = cand_v && ((depth_d == '0) || (cand_i < top_d));
        if (preempt && (depth_d == DW'(NEST_MAX))) state_d = ST_FULL;
        else if (preempt)                          state_d = ST_OFFER;
        else if (depth_d != '0)                    state_d = ST_BUSY;
        else                                       state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            vec_q   <= cand_v ? cand_i : '0;
        end
    end

    // outputs
    always_comb begin
        irq_req  = 1'b0;
        nest_ovf = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_OFFER: irq_req  = 1'b1;
            ST_BUSY:  ;
            ST_FULL:  nest_ovf = 1'b1;
        endcase
        irq_vec    = vec_q;
        nest_depth = depth_q;
        pend_flags = flags_q;
        hold_on    = hold_on_q;
    end
endmodule

// File: rtl/irqn_chk.sv
module irqn_chk
    import irqn_pkg::*;
#(
    parameter  int NEST_MAX = 16,
    localparam int DW       = $clog2(NEST_MAX + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctrl_we,
    input logic [1:0]      ctrl_addr,
    input logic [CW-1:0]   ctrl_wdata,
    input logic            irq_ack,
    input logic            irq_ret,
    input logic            irq_req,
    input logic [VW-1:0]   irq_vec,
    input logic            nest_ovf,
    input logic [DW-1:0]   nest_depth,
    input logic [NSRC-1:0] pend_flags,
    input logic            hold_on
);
    a_r10_req_ovf_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_req && nest_ovf));

    a_r10_ovf_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        nest_ovf |-> (nest_depth == DW'(NEST_MAX)));

    a_r2_offer_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> pend_flags[irq_vec]);

    a_r7_ack_push: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !irq_ret) |=> (nest_depth == $past(nest_depth) + DW'(1)));

    a_r7_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_req && !irq_ret) |=> $stable(nest_depth));

    a_r9_ret_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !(irq_ack && irq_req) && (nest_depth != '0))
            |=> (nest_depth == $past(nest_depth) - DW'(1)));

    a_r9_ret_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_ack && (nest_depth == '0)) |=> (nest_depth == '0));

    a_r4_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_on && !(ctrl_we && (ctrl_addr == REG_CLR) && ctrl_wdata[HOLD_CLR_BIT]))
            |=> hold_on);
endmodule

bind irq_nest_ctrl irqn_chk #(.NEST_MAX(NEST_MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_addr  (ctrl_addr),
    .ctrl_wdata (ctrl_wdata),
    .irq_ack    (irq_ack),
    .irq_ret    (irq_ret),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .nest_ovf   (nest_ovf),
    .nest_depth (nest_depth),
    .pend_flags (pend_flags),
    .hold_on    (hold_on)
);

// File: tb/sim_irq_nest_ctrl.sv
module sim_irq_nest_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_hold = 1'b1;
    logic [5:0]  pin_int = 6'h3F;
    logic [6:0]  per_pulse = '0;
    logic        ctrl_we = 1'b0;
    logic [1:0]  ctrl_addr = '0;
    logic [14:0] ctrl_wdata = '0;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;

    logic        req0, ovf0, hon0;
    logic [3:0]  vec0;
    logic [4:0]  dep0;
    logic [13:0] pend0;
    logic        req1, ovf1, hon1;
    logic [3:0]  vec1;
    logic [2:0]  dep1;
    logic [13:0] pend1;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    irq_nest_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_hold(pin_hold), .pin_int(pin_int),
        .per_pulse(per_pulse), .ctrl_we(ctrl_we), .ctrl_addr(ctrl_addr),
        .ctrl_wdata(ctrl_wdata), .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq_req(req0), .irq_vec(vec0), .nest_ovf(ovf0), .nest_depth(dep0),
        .pend_flags(pend0), .hold_on(hon0)
    );

    irq_nest_ctrl #(.NEST_MAX(4)) u1 (
        .clk(clk), .rst_n(rst_n), .pin_hold(pin_hold), .pin_int(pin_int),
        .per_pulse(per_pulse), .ctrl_we(ctrl_we), .ctrl_addr(ctrl_addr),
        .ctrl_wdata(ctrl_wdata), .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq_req(req1), .irq_vec(vec1), .nest_ovf(ovf1), .nest_depth(dep1),
        .pend_flags(pend1), .hold_on(hon1)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [14:0] d);
        ctrl_we = 1'b1; ctrl_addr = a; ctrl_wdata = d;
        tick();
        ctrl_we = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] m);
        per_pulse = m;
        tick();
        per_pulse = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    task automatic ret();
        irq_ret = 1'b1;
        tick();
        irq_ret = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; pin_hold = 1'b1; pin_int = 6'h3F; per_pulse = '0;
        ctrl_we = 1'b0; irq_ack = 1'b0; irq_ret = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        repeat (4) tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 irq_req", req0, 0);
        chk("R1 nest_ovf", ovf0, 0);
        chk("R1 nest_depth", dep0, 0);
        chk("R1 pend_flags", pend0, 0);
        chk("R1 hold_on", hon0, 0);
    endtask

    task automatic t_pins();
        do_reset();
        wr(2'd0, 15'h3FFF);
        wr(2'd1, 15'h0002);            // pin 1 rising, others falling
        pin_int[0] = 1'b0;
        repeat (2) tick();
        chk("R11 flag not before two sync stages", pend0[1], 0);
        tick();
        chk("R11 R3 falling edge latched", pend0[1], 1);
        chk("R2 vector of pin 0", vec0, 1);
        chk("R11 request with flag", req0, 1);
        wr(2'd2, 15'h0002);
        chk("R12 write-one clear", pend0[1], 0);
        pin_int[0] = 1'b1;
        repeat (4) tick();
        chk("R3 rising ignored on falling pin", pend0[1], 0);
        pin_int[1] = 1'b0;
        repeat (4) tick();
        chk("R3 falling ignored on rising pin", pend0[2], 0);
        pin_int[1] = 1'b1;
        repeat (4) tick();
        chk("R3 rising latched on rising pin", pend0[2], 1);
        wr(2'd2, 15'h0004);
        wr(2'd0, 15'h3FFF & ~15'h0408); // disable pin 2 and timer 0
        pin_int[2] = 1'b0;
        repeat (4) tick();
        chk("R5 disabled pin", pend0[3], 0);
        pulse(7'b0001000);
        chk("R5 disabled pulse", pend0[10], 0);
        chk("R5 no request", req0, 0);
    endtask

    task automatic t_hold();
        do_reset();
        wr(2'd0, 15'h3FFE);
        pin_hold = 1'b0;
        repeat (3) tick();
        chk("R4 status set while disabled", hon0, 1);
        chk("R4 R5 flag gated", pend0[0], 0);
        wr(2'd2, 15'h4000);
        chk("R4 status cleared", hon0, 0);
        pin_hold = 1'b1;
        repeat (4) tick();
        chk("R4 rising ignored", hon0, 0);
        wr(2'd0, 15'h3FFF);
        pin_hold = 1'b0;
        pin_int[0] = 1'b0;
        repeat (3) tick();
        chk("R2 monitor beats pin 0", vec0, 0);
        chk("R4 flag set when enabled", pend0[0], 1);
        ack();
        chk("R8 less urgent waits", req0, 0);
        chk("R7 depth after ack", dep0, 1);
    endtask

    task automatic t_prio();
        do_reset();
        wr(2'd0, 15'h3FFF);
        pulse(7'b1001001);              // sources 7, 10, 13
        chk("R11 R2 serial 0 wins", vec0, 7);
        chk("R11 request same cycle", req0, 1);
        ack();
        chk("R7 flag cleared", pend0[7], 0);
        chk("R8 lower pending blocked", req0, 0);
        ret();
        chk("R9 return pops", dep0, 0);
        chk("R2 next is timer 0", vec0, 10);
        ack(); ret();
        chk("R2 last is timer 3", vec0, 13);
        ack(); ret();
        pin_int[3] = 1'b0;
        pulse(7'b0000001);
        chk("R11 pin not yet through", vec0, 7);
        repeat (2) tick();
        chk("R2 pin 3 beats serial 0", vec0, 4);
    endtask

    task automatic t_nest();
        do_reset();
        wr(2'd0, 15'h3FFF);
        pulse(7'b1000000);
        ack();
        chk("R7 depth one", dep0, 1);
        pulse(7'b1000000);
        pulse(7'b1000000);
        chk("R8 equal level not offered", req0, 0);
        chk("R6 flag held", pend0[13], 1);
        pulse(7'b0000010);
        chk("R8 preempt offered", req0, 1);
        chk("R8 preempt vector", vec0, 8);
        ack();
        chk("R7 depth two", dep0, 2);
        ack();
        chk("R7 ack without request ignored", dep0, 2);
        ret();
        chk("R9 pop to one", dep0, 1);
        chk("R8 still not higher", req0, 0);
        ret();
        chk("R9 revealed", vec0, 13);
        ack();
        chk("R6 absorbed edges consumed", pend0[13], 0);
        ret(); ret();
        chk("R9 return at empty", dep0, 0);
        chk("R9 idle", req0, 0);
    endtask

    task automatic t_ovf();
        do_reset();
        wr(2'd0, 15'h3FFF);
        for (int b = 6; b >= 3; b--) begin
            pulse(7'(1) << b);
            ack();
        end
        chk("R10 shallow depth full", dep1, 4);
        pulse(7'b0000100);               // serial 2
        chk("R10 overflow raised", ovf1, 1);
        chk("R10 request blocked", req1, 0);
        chk("R8 deep stack offers", req0, 1);
        ret();
        chk("R10 overflow released", ovf1, 0);
        chk("R10 offered after return", req1, 1);
        chk("R10 vector", vec1, 9);
    endtask

    initial begin
        t_reset();
        t_pins();
        t_hold();
        t_prio();
        t_nest();
        t_ovf();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule